// File: doc/BRIEF.md
# SDRAM Command Sequencer with Single-Page Tracking

This block drives one chip select of an SDRAM device. It takes memory requests from an internal bus and produces the device's control strobes, clock enable and shared address pins. It keeps a record of one open row. A request whose row matches that record goes straight to a column command. A request to another row first closes every bank and then opens the new row. Reads and writes are either single-beat or four-beat bursts. The block marks each data beat on a strobe, and the data path that uses that strobe lives outside it.

After reset the sequencer waits through a power-up interval. It then closes all banks, issues two auto refreshes and programs the mode register, and only after that does it accept requests. An internal timer, reloaded from a programmable period input, requests auto refreshes. These refreshes are served only between accesses. A control input moves the device into low-power self-refresh and later brings it back out.

Requests arrive on a valid/ready channel. The bus holds `req_valid` and its fields stable until a cycle in which `req_ready` is also high, and that cycle accepts the request. `req_ready` stays low from acceptance until the cycle after the last data beat, during initialisation, while a refresh is pending and during self-refresh. This low level is the only back-pressure the block applies.

Top module: `sdram_seq`

## Requirements
- R1: After reset `sd_cke` is high and the command is no-op for INIT_CYC cycles. Then precharge-all (sd_a bit 10 high), two auto refreshes and a mode register set carrying MODE_WORD on `sd_a` follow, and `req_ready` stays low until that sequence has ended.
- R2: The command on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} is encoded as follows: no-op 0111, activate 0011, read 0101, write 0100, precharge-all 0010, auto/self refresh 0001, mode register set 0000. `sd_cs_n` is always low, and no command other than these is produced.
- R3: When no row is open, an accepted request gives activate in the first cycle after acceptance and the column command in the second.
- R4: When the requested row equals the open row, the read or write is issued in the first cycle after acceptance, with no precharge or activate.
- R5: When a different row is open, the sequencer issues precharge-all, then activate of the new row, then the column command, in three consecutive cycles.
- R6: `data_beat` is high for one cycle (req_burst=0) or four consecutive cycles (req_burst=1). The first beat comes BEAT_LAT cycles after the read or write command, which gives a page-hit burst read its beats in cycles 5, 6, 7 and 8 after acceptance.
- R7: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the cycle after the last beat, and it is high again in that cycle. A request held while `req_ready` is low causes no command.
- R8: The refresh timer expires every ctl_ref_period+1 cycles. A pending refresh is served only when idle, as precharge-all followed by auto refresh, and it leaves no row open, so the next access starts with activate.
- R9: When `ctl_self` is high while idle, the sequencer issues precharge-all and then the refresh encoding with `sd_cke` low. `sd_cke` stays low while `ctl_self` stays high. Clearing `ctl_self` raises `sd_cke` for one no-op exit cycle and returns to idle with no row open.
- R10: Activate drives the row (req_addr[19:8]) on `sd_a`. Read and write drive the column (req_addr[7:0]) zero-extended with bit 10 low. All other commands drive `sd_a` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_addr | input | 20 | {row[11:0], column[7:0]} |
| ctl_self | input | 1 | Hold device in self-refresh while high |
| ctl_ref_period | input | 12 | Refresh timer reload value |
| data_beat | output | 1 | Marks a data beat cycle |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a | output | 12 | Multiplexed row/column/mode address |

## Verification
A stale or lost open-row record is the most likely fault, and it shows at the pins within one to three cycles of the next acceptance. A hit then gets an extra precharge and activate, or a miss gets a bare read or write with no activate in front of it. A lost refresh request, or one served twice, changes the spacing of auto refresh commands away from ctl_ref_period+1 cycles. A wrong beat count or latency shifts `data_beat` within BEAT_LAT+4 cycles of the column command, and it also moves the cycle in which `req_ready` comes back.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PALL  = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WRITE = 4'b0100,
    CMD_READ  = 4'b0101,
    CMD_NOP   = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_IPRE, ST_IREF, ST_IMRS, ST_IDLE, ST_PRE, ST_ACT, ST_RW,
    ST_DATA, ST_RPRE, ST_REF, ST_SPRE, ST_SENT, ST_SLEEP, ST_SEXIT
  } seq_st_e;
endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic          ack_i,
  output logic          pend_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (cnt_q == '0) begin
        cnt_q  <= period_i;
        pend_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (ack_i) pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_page_track.sv
module sdram_page_track #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             close_all,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             is_open,
  output logic             hit
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (close_all) begin
      is_open <= 1'b0;
    end else if (open_set) begin
      is_open <= 1'b1;
      row_q   <= set_row;
    end
  end

  assign hit = is_open && (cmp_row == row_q);
endmodule

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux
  import sdram_seq_pkg::*;
#(
  parameter int              ROW_W     = 12,
  parameter int              COL_W     = 8,
  parameter int              SA_W      = 12,
  parameter int              AP_BIT    = 10,
  parameter logic [SA_W-1:0] MODE_WORD = '0
) (
  input  sd_cmd_e          cmd,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic [SA_W-1:0]  a
);
  always_comb begin
    a = '0;
    case (cmd)
      CMD_ACT:             a = SA_W'(row);
      CMD_READ, CMD_WRITE: begin
        a         = SA_W'(col);
        a[AP_BIT] = 1'b0;
      end
      CMD_PALL:            a[AP_BIT] = 1'b1;
      CMD_MRS:             a = MODE_WORD;
      default:             a = '0;
    endcase
  end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int              ROW_W     = 12,
  parameter int              COL_W     = 8,
  parameter int              SA_W      = 12,
  parameter int              AP_BIT    = 10,
  parameter int              RC_W      = 12,
  parameter int              INIT_CYC  = 8,
  parameter int              BEAT_LAT  = 4,
  parameter int              BURST_LEN = 4,
  parameter logic [SA_W-1:0] MODE_WORD = 'h042
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_burst,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   ctl_self,
  input  logic [RC_W-1:0]        ctl_ref_period,
  output logic                   data_beat,
  output logic                   sd_cke,
  output logic                   sd_cs_n,
  output logic                   sd_ras_n,
  output logic                   sd_cas_n,
  output logic                   sd_we_n,
  output logic [SA_W-1:0]        sd_a
);
  localparam int AW    = ROW_W + COL_W;
  localparam int CNT_W = $clog2(INIT_CYC + BEAT_LAT + BURST_LEN + 2) + 1;

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;
  logic [ROW_W-1:0] row_q, req_row;
  logic [COL_W-1:0] col_q;
  logic             wr_q, burst_q;
  logic             ref_pend, page_open, page_hit, accept;
  sd_cmd_e          cmd;

  assign req_row  = req_addr[AW-1:COL_W];
  assign req_ready = (st_q == ST_IDLE) && !ctl_self && !ref_pend;
  assign accept   = req_valid && req_ready;
  assign last_cnt = burst_q ? CNT_W'(BEAT_LAT + BURST_LEN - 2) : CNT_W'(BEAT_LAT - 1);

  sdram_refresh_timer #(.CW(RC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_i(ctl_ref_period),
    .ack_i(cmd == CMD_REF), .pend_o(ref_pend)
  );

  sdram_page_track #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst_n(rst_n), .open_set(st_q == ST_ACT),
    .close_all(cmd == CMD_PALL), .set_row(row_q), .cmp_row(req_row),
    .is_open(page_open), .hit(page_hit)
  );

  sdram_addr_mux #(
    .ROW_W(ROW_W), .COL_W(COL_W), .SA_W(SA_W), .AP_BIT(AP_BIT), .MODE_WORD(MODE_WORD)
  ) u_amux (
    .cmd(cmd), .row(row_q), .col(col_q), .a(sd_a)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_PWR:
        if (cnt_q == CNT_W'(INIT_CYC - 1)) begin
          st_d  = ST_IPRE;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      ST_IPRE: st_d = ST_IREF;
      ST_IREF:
        if (cnt_q == CNT_W'(1)) begin
          st_d  = ST_IMRS;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      ST_IMRS: st_d = ST_IDLE;
      ST_IDLE:
        if (ctl_self)       st_d = ST_SPRE;
        else if (ref_pend)  st_d = ST_RPRE;
        else if (req_valid) st_d = page_hit ? ST_RW : (page_open ? ST_PRE : ST_ACT);
      ST_PRE:  st_d = ST_ACT;
      ST_ACT:  st_d = ST_RW;
      ST_RW: begin
        st_d  = ST_DATA;
        cnt_d = '0;
      end
      ST_DATA:
        if (cnt_q == last_cnt) st_d = ST_IDLE;
        else cnt_d = cnt_q + 1'b1;
      ST_RPRE:  st_d = ST_REF;
      ST_REF:   st_d = ST_IDLE;
      ST_SPRE:  st_d = ST_SENT;
      ST_SENT:  st_d = ST_SLEEP;
      ST_SLEEP: if (!ctl_self) st_d = ST_SEXIT;
      ST_SEXIT: st_d = ST_IDLE;
      default:  st_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_PWR;
      cnt_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (accept) begin
        row_q   <= req_row;
        col_q   <= req_addr[COL_W-1:0];
        wr_q    <= req_write;
        burst_q <= req_burst;
      end
    end
  end

  always_comb begin
    case (st_q)
      ST_ACT:                             cmd = CMD_ACT;
      ST_RW:                              cmd = wr_q ? CMD_WRITE : CMD_READ;
      ST_IPRE, ST_PRE, ST_RPRE, ST_SPRE:  cmd = CMD_PALL;
      ST_IREF, ST_REF, ST_SENT:           cmd = CMD_REF;
      ST_IMRS:                            cmd = CMD_MRS;
      default:                            cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke    = !((st_q == ST_SENT) || (st_q == ST_SLEEP));
  assign data_beat = (st_q == ST_DATA) && (cnt_q >= CNT_W'(BEAT_LAT - 1));
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int SA_W   = 12,
  parameter int AP_BIT = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            data_beat,
  input logic            sd_cke,
  input logic [3:0]      cmd_i,
  input logic [SA_W-1:0] sd_a
);
  // R3: an activate is always followed by its column command
  p_act_then_rw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_ACT) |=> (cmd_i == CMD_READ || cmd_i == CMD_WRITE));

  // R5: precharge carries the all-banks bit
  p_pre_allbanks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_PALL) |-> sd_a[AP_BIT]);

  // R10: column commands never request auto precharge
  p_rw_no_ap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_READ || cmd_i == CMD_WRITE) |-> !sd_a[AP_BIT]);

  // R8: every refresh follows a precharge or another refresh
  p_ref_after_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_REF) |-> ($past(cmd_i) == CMD_PALL || $past(cmd_i) == CMD_REF));

  // R6: beats happen on a quiet bus with no new request taken
  p_beat_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_beat |-> (cmd_i == CMD_NOP && !req_ready));

  // R7: acceptance closes the channel for the next cycle
  p_accept_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: clock enable drops only right after a precharge-all
  p_cke_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cke) |-> ($past(cmd_i) == CMD_PALL));

  // R9: no request is taken while clock enable is low
  p_no_accept_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> !req_ready);
endmodule

bind sdram_seq sdram_seq_chk #(.SA_W(SA_W), .AP_BIT(AP_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .data_beat(data_beat), .sd_cke(sd_cke),
  .cmd_i({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), .sd_a(sd_a)
);

// File: tb/sdram_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_seq_tb_top;
  localparam int LAT = 4;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, ctl_self = 1'b0;
  logic [19:0] req_addr = '0;
  logic [11:0] ctl_ref_period = 12'd4095;
  logic req_ready, data_beat, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_a;

  always #2 clk = ~clk;

  sdram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .ctl_self(ctl_self), .ctl_ref_period(ctl_ref_period), .data_beat(data_beat),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_a(sd_a)
  );

  typedef struct { logic [16:0] v; string tag; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, nop_cnt = 0, ref_n = 0;
  int ref_cyc[16];
  bit seen_cmd = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [11:0] a, input logic cke, input string tag);
    item_t it;
    it.v = {cke, c, a};
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor: every non-no-op command is popped and compared
  always @(negedge clk) begin
    logic [3:0] c;
    item_t e;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n) begin
      if (c == C_NOP) begin
        if (!seen_cmd) nop_cnt++;
      end else begin
        seen_cmd = 1;
        if (c == C_REF && sd_cke && ref_n < 16) begin
          ref_cyc[ref_n] = cyc;
          ref_n++;
        end
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected command", {sd_cke, c, sd_a}, 0);
        end else begin
          e = exp_q.pop_front();
          chk({sd_cke, c, sd_a} == e.v, e.tag, "command/cke/address", {sd_cke, c, sd_a}, e.v);
        end
      end
    end
  end

  task automatic do_access(input bit wr, input bit bst, input logic [11:0] row,
                           input logic [7:0] col, input int rw_off, input string tag);
    int nb;
    logic [31:0] got_m, exp_m;
    bit rdy_ok;
    nb = bst ? 4 : 1;
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_burst = bst; req_addr = {row, col};
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
    got_m = '0; exp_m = '0; rdy_ok = 1;
    for (int k = 1; k < rw_off + LAT + nb; k++) begin
      @(negedge clk);
      if (data_beat) got_m[k] = 1'b1;
      if (k >= rw_off + LAT) exp_m[k] = 1'b1;
      if (req_ready) rdy_ok = 0;
    end
    @(negedge clk);
    chk(got_m == exp_m, tag, "data beat cycles after accept (R6)", got_m, exp_m);
    chk(rdy_ok, "R7", "ready low during access", rdy_ok, 1);
    chk(req_ready == 1'b1, "R7", "ready back after last beat", req_ready, 1);
    chk(exp_q.size() == 0, tag, "all expected commands seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: power-up sequence
    push(C_PRE, 12'h400, 1, "R1");
    push(C_REF, 12'h000, 1, "R1");
    push(C_REF, 12'h000, 1, "R1");
    push(C_MRS, 12'h042, 1, "R1");
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
    chk(sd_cke == 1'b1, "R1", "cke in reset", sd_cke, 1);
    chk(sd_cs_n == 1'b0, "R2", "chip select held", sd_cs_n, 0);
    @(posedge clk); #1;
    rst_n = 1;
    do @(negedge clk); while (!req_ready);
    chk(exp_q.size() == 0, "R1", "init commands before ready", exp_q.size(), 0);
    chk(nop_cnt == 8, "R1", "power-up no-op cycles", nop_cnt, 8);

    // R3: no page open -> activate then read
    push(C_ACT, 12'h005, 1, "R3");
    push(C_RD, 12'h010, 1, "R10");
    do_access(0, 0, 12'h005, 8'h10, 2, "R3");

    // R4/R6: hit burst read, beats 5..8 after accept
    push(C_RD, 12'h020, 1, "R4");
    do_access(0, 1, 12'h005, 8'h20, 1, "R6");

    // R4: hit single write
    push(C_WR, 12'h021, 1, "R4");
    do_access(1, 0, 12'h005, 8'h21, 1, "R4");

    // R5: miss burst write
    push(C_PRE, 12'h400, 1, "R5");
    push(C_ACT, 12'h009, 1, "R5");
    push(C_WR, 12'h040, 1, "R10");
    do_access(1, 1, 12'h009, 8'h40, 3, "R5");

    // R4: hit on the new row
    push(C_RD, 12'h044, 1, "R4");
    do_access(0, 0, 12'h009, 8'h44, 1, "R4");

    // R8: refresh period and sequence
    @(posedge clk); #1;
    ctl_ref_period = 12'd30;
    for (int i = 0; i < 4; i++) begin
      push(C_PRE, 12'h400, 1, "R8");
      push(C_REF, 12'h000, 1, "R8");
    end
    while (ref_n < 5) @(negedge clk);
    @(posedge clk); #1;
    ctl_ref_period = 12'd4095;
    while (ref_n < 6) @(negedge clk);
    chk(ref_cyc[3] - ref_cyc[2] == 31, "R8", "refresh interval a", ref_cyc[3] - ref_cyc[2], 31);
    chk(ref_cyc[4] - ref_cyc[3] == 31, "R8", "refresh interval b", ref_cyc[4] - ref_cyc[3], 31);

    // R8: refresh closed the page -> activate without precharge
    push(C_ACT, 12'h009, 1, "R8");
    push(C_RD, 12'h003, 1, "R10");
    do_access(0, 0, 12'h009, 8'h03, 2, "R8");

    // R9: self-refresh with a request held off
    push(C_PRE, 12'h400, 1, "R9");
    push(C_REF, 12'h000, 0, "R9");
    @(posedge clk); #1;
    ctl_self = 1;
    req_valid = 1; req_write = 0; req_burst = 0; req_addr = {12'h007, 8'h01};
    repeat (4) @(negedge clk);
    begin
      bit asleep_ok;
      asleep_ok = 1;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (sd_cke || req_ready) asleep_ok = 0;
      end
      chk(asleep_ok, "R9", "cke low and ready low while asleep", asleep_ok, 1);
    end
    chk(exp_q.size() == 0, "R7", "held request issued nothing", exp_q.size(), 0);
    push(C_ACT, 12'h007, 1, "R9");
    push(C_RD, 12'h001, 1, "R9");
    @(posedge clk); #1;
    ctl_self = 0;
    do_access(0, 0, 12'h007, 8'h01, 2, "R9");
    chk(sd_cke == 1'b1, "R9", "cke high after exit", sd_cke, 1);

    finish_run();
  end
endmodule